// File: doc/BRIEF.md
# Streaming SPI Slave with Word Repeat

This block is an SPI slave. An external master drives a serial clock and an active-low select. The block shifts serial words in on MOSI and out on MISO, most significant bit first, and the word width is a parameter. Two static mode pins choose the clock idle level and the sampling phase, so all four SPI modes are available. The serial lines are brought into the system clock domain through register synchronizers. Edge detection, bit sequencing and the parallel interface then run on that one clock.

On the user side, a word is written with a one-cycle strobe and is acknowledged one cycle later. The word waits in a one-deep holding register until the next word boundary. Every word that arrives from the master is presented on the read port with a one-cycle valid pulse.

The master may clock any number of words while select stays low. The stream never stalls for the user. At each word boundary the held word is sent if there is one; otherwise the word sent last goes out again. Raising select drops any partial word and returns the bit sequencer to its idle state.

Top module: `spis_stream_slave`

## Requirements
- R1: Incoming bits are sampled on the rising serial-clock edge when `cfg_cpol` equals `cfg_cpha`, and on the falling edge otherwise. MISO changes only on the opposite edge, or when a select starts.
- R2: Words are WORD_W bits wide (default 8) and travel MSB first in both directions.
- R3: With `cfg_cpha`=0, the MSB of the outgoing word is on MISO once select has been low for the synchronizer latency, before any clock edge. With `cfg_cpha`=1 it appears after the first edge.
- R4: After the last sampling edge of each complete word, `rx_data` holds that word and `rx_valid` is high for exactly one cycle.
- R5: A `tx_wr` pulse stores `tx_data` in the holding register, and `tx_ack` is high in the next cycle. A later write before the next boundary replaces the earlier one.
- R6: While select stays low, words follow back to back without user action. A boundary with no new held word resends the previous word.
- R7: A word written in the middle of a word leaves that word unchanged and is sent from the next boundary on.
- R8: A write captured in the same cycle as a word-boundary load does not take part in that load. The boundary resends the earlier word, and the new word is sent at the following boundary.
- R9: Raising select drops a partial word without an `rx_valid` pulse and clears the bit count. MISO is 0 whenever the block is not selected.
- R10: After synchronous reset, MISO, `rx_valid` and `tx_ack` are 0 and the last-sent word is all zeros. A stream with no writes therefore sends zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_cpol | input | 1 | Serial clock idle level (static while selected) |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| spi_sck | input | 1 | Serial clock from the master |
| spi_ss_n | input | 1 | Slave select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| tx_data | input | WORD_W | Word to send |
| tx_wr | input | 1 | Write strobe for `tx_data` |
| tx_ack | output | 1 | Write acknowledge, one cycle after `tx_wr` |
| rx_data | output | WORD_W | Last complete received word |
| rx_valid | output | 1 | One-cycle pulse when `rx_data` is updated |

## Verification
A user write and a word-boundary load can fall in the same system cycle. The write then lands in the holding register just as the boundary decides between the held word and a repeat. The bench provokes this by timing a write strobe to the exact cycle in which the synchronized boundary edge takes effect. This cycle is the synchronizer depth plus one cycles after the serial clock toggles. The bench judges the case from the words the master captures: the boundary word must repeat the previous word, and the written word must follow at the next boundary. A second run places the write in the middle of a word to separate this case from the ordinary hand-over.

// File: rtl/spis_pkg.sv
package spis_pkg;

  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_SHIFT = 1'b1
  } spis_state_e;

  // Sampling edge is the rising one when idle level and phase agree.
  function automatic logic spis_sample_on_rise(input logic cpol, input logic cpha);
    return ~(cpol ^ cpha);
  endfunction

endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {STAGES{RST_VAL}};
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/spis_edge_det.sv
module spis_edge_det
  import spis_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sck_s,
  input  logic ss_n_s,
  input  logic cpol,
  input  logic cpha,
  output logic sample_evt,
  output logic change_evt,
  output logic sel_start,
  output logic sel_end,
  output logic ss_act
);

  logic sck_q;
  logic act_q;
  logic act_now;
  logic both_act;
  logic rise;
  logic fall;
  logic on_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= cpol;
      act_q <= 1'b0;
    end else begin
      sck_q <= sck_s;
      act_q <= ~ss_n_s;
    end
  end

  assign act_now  = ~ss_n_s;
  assign both_act = act_now & act_q;
  assign rise     = sck_s & ~sck_q & both_act;
  assign fall     = ~sck_s & sck_q & both_act;
  assign on_rise  = spis_sample_on_rise(cpol, cpha);

  assign sample_evt = on_rise ? rise : fall;
  assign change_evt = on_rise ? fall : rise;
  assign sel_start  = act_now & ~act_q;
  assign sel_end    = ~act_now & act_q;
  assign ss_act     = act_q;

endmodule

// File: rtl/spis_bit_fsm.sv
module spis_bit_fsm
  import spis_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int CNT_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_evt,
  input  logic              sel_end,
  input  logic              mosi_s,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  spis_state_e       state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] rx_q, rx_d;
  logic              done_d;

  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] c);
    return (c == LAST) ? '0 : c + 1'b1;
  endfunction

  always_comb begin
    case (state_q)
      ST_IDLE: begin
        if (sample_evt) begin
          state_d = ST_SHIFT;
          cnt_d   = step_count('0);
          rx_d    = {rx_q[WORD_W-2:0], mosi_s};
          done_d  = 1'b0;
        end else begin
          state_d = ST_IDLE;
          cnt_d   = '0;
          rx_d    = rx_q;
          done_d  = 1'b0;
        end
      end
      ST_SHIFT: begin
        if (sel_end) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
          rx_d    = rx_q;
          done_d  = 1'b0;
        end else if (sample_evt) begin
          state_d = ST_SHIFT;
          cnt_d   = step_count(cnt_q);
          rx_d    = {rx_q[WORD_W-2:0], mosi_s};
          done_d  = (cnt_q == LAST);
        end else begin
          state_d = ST_SHIFT;
          cnt_d   = cnt_q;
          rx_d    = rx_q;
          done_d  = 1'b0;
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
        rx_d    = rx_q;
        done_d  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      rx_q     <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      rx_q     <= rx_d;
      rd_valid <= done_d;
      if (done_d) rd_data <= rx_d;
    end
  end

  assign bit_cnt = cnt_q;

endmodule

// File: rtl/spis_tx_path.sv
module spis_tx_path #(
  parameter int WORD_W = 8,
  parameter int CNT_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              change_evt,
  input  logic              sel_start,
  input  logic              cpha,
  input  logic              ss_act,
  input  logic [CNT_W-1:0]  bit_cnt,
  output logic              load_evt,
  output logic              wr_ack,
  output logic              miso
);

  logic [WORD_W-1:0] pend_q;
  logic              pend_vld_q;
  logic [WORD_W-1:0] last_q;
  logic [WORD_W-1:0] sreg_q;

  // A word starts at a change edge with no bits sampled yet, or at select
  // start when the first bit must be present before the first edge.
  assign load_evt = (change_evt && (bit_cnt == '0)) || (sel_start && !cpha);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
      last_q     <= '0;
      sreg_q     <= '0;
      wr_ack     <= 1'b0;
    end else begin
      wr_ack <= wr_en;
      if (load_evt) begin
        if (pend_vld_q) begin
          sreg_q <= pend_q;
          last_q <= pend_q;
        end else begin
          sreg_q <= last_q;
        end
      end else if (change_evt) begin
        sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
      end
      if (wr_en) begin
        pend_q     <= wr_data;
        pend_vld_q <= 1'b1;
      end else if (load_evt) begin
        pend_vld_q <= 1'b0;
      end
    end
  end

  assign miso = ss_act ? sreg_q[WORD_W-1] : 1'b0;

endmodule

// File: rtl/spis_stream_slave.sv
module spis_stream_slave #(
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              spi_sck,
  input  logic              spi_ss_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_wr,
  output logic              tx_ack,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid
);

  localparam int CNT_W = $clog2(WORD_W);

  logic [2:0]       line_s;
  logic             sck_s, ss_n_s, mosi_s;
  logic             sample_evt, change_evt, sel_start, sel_end, ss_act;
  logic             load_evt;
  logic [CNT_W-1:0] bit_cnt;

  // Bit order: {sck, ss_n, mosi}; select resets to inactive.
  spis_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({spi_sck, spi_ss_n, spi_mosi}),
    .q   (line_s)
  );

  assign sck_s  = line_s[2];
  assign ss_n_s = line_s[1];
  assign mosi_s = line_s[0];

  spis_edge_det u_edge (
    .clk        (clk),
    .rst        (rst),
    .sck_s      (sck_s),
    .ss_n_s     (ss_n_s),
    .cpol       (cfg_cpol),
    .cpha       (cfg_cpha),
    .sample_evt (sample_evt),
    .change_evt (change_evt),
    .sel_start  (sel_start),
    .sel_end    (sel_end),
    .ss_act     (ss_act)
  );

  spis_bit_fsm #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .sample_evt (sample_evt),
    .sel_end    (sel_end),
    .mosi_s     (mosi_s),
    .bit_cnt    (bit_cnt),
    .rd_data    (rx_data),
    .rd_valid   (rx_valid)
  );

  spis_tx_path #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (tx_wr),
    .wr_data    (tx_data),
    .change_evt (change_evt),
    .sel_start  (sel_start),
    .cpha       (cfg_cpha),
    .ss_act     (ss_act),
    .bit_cnt    (bit_cnt),
    .load_evt   (load_evt),
    .wr_ack     (tx_ack),
    .miso       (spi_miso)
  );

endmodule

// File: rtl/spis_stream_slave_chk.sv
module spis_stream_slave_chk #(
  parameter int WORD_W = 8,
  parameter int CNT_W  = $clog2(WORD_W)
) (
  input logic             clk,
  input logic             rst,
  input logic             ss_act,
  input logic             sel_end,
  input logic             chg_evt,
  input logic             load_evt,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             miso,
  input logic             wr,
  input logic             ack,
  input logic             rx_valid
);

  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid) else $error("rx_valid longer than one cycle");

  p_ack_follows_r5: assert property (@(posedge clk) disable iff (rst)
    wr |=> ack) else $error("missing write acknowledge");

  p_no_spurious_ack_r5: assert property (@(posedge clk) disable iff (rst)
    !wr |=> !ack) else $error("acknowledge without write");

  p_idle_miso_r9: assert property (@(posedge clk) disable iff (rst)
    !ss_act |-> (miso == 1'b0)) else $error("MISO not idle when deselected");

  p_abort_clear_r9: assert property (@(posedge clk) disable iff (rst)
    sel_end |=> (bit_cnt == '0)) else $error("bit count kept after deselect");

  p_no_valid_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (!ss_act && $past(!ss_act)) |-> !rx_valid) else $error("rx_valid while deselected");

  p_miso_edge_r1: assert property (@(posedge clk) disable iff (rst)
    (ss_act && $past(ss_act) && !$past(chg_evt) && !$past(load_evt)) |-> $stable(miso))
    else $error("MISO moved outside its change edge");

endmodule

bind spis_stream_slave spis_stream_slave_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ss_act   (ss_act),
  .sel_end  (sel_end),
  .chg_evt  (change_evt),
  .load_evt (load_evt),
  .bit_cnt  (bit_cnt),
  .miso     (spi_miso),
  .wr       (tx_wr),
  .ack      (tx_ack),
  .rx_valid (rx_valid)
);

// File: tb/spis_stream_slave_tb_top.sv
`timescale 1ns/1ps
module spis_stream_slave_tb_top;

  localparam int W      = 8;
  localparam int H      = 6;   // serial half period in system cycles
  localparam int SETTLE = 8;

  // Vector: {cpol, cpha, master word, slave word}
  localparam logic [17:0] VEC [8] = '{
    {1'b0, 1'b0, 8'hA3, 8'h5C},
    {1'b0, 1'b1, 8'h81, 8'h7E},
    {1'b1, 1'b0, 8'hF0, 8'h0F},
    {1'b1, 1'b1, 8'h69, 8'h96},
    {1'b0, 1'b0, 8'hFF, 8'h00},
    {1'b0, 1'b1, 8'h00, 8'hFF},
    {1'b1, 1'b0, 8'h12, 8'hC8},
    {1'b1, 1'b1, 8'hE1, 8'h3B}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cpol = 1'b0, cpha = 1'b0;
  logic         sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
  logic [W-1:0] tx_data = '0;
  logic         tx_wr = 1'b0;
  logic         miso, tx_ack, rx_valid;
  logic [W-1:0] rx_data;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [W-1:0] rx_log [64];
  int           rx_cnt = 0;
  logic [W-1:0] mo_a  [4];
  logic [W-1:0] mi_a  [4];
  logic [W-1:0] exp_a [4];

  always #2.5 clk = ~clk;

  spis_stream_slave #(.WORD_W(W)) dut_i (
    .clk(clk), .rst(rst), .cfg_cpol(cpol), .cfg_cpha(cpha),
    .spi_sck(sck), .spi_ss_n(ss_n), .spi_mosi(mosi), .spi_miso(miso),
    .tx_data(tx_data), .tx_wr(tx_wr), .tx_ack(tx_ack),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );

  always @(negedge clk) begin
    if (!rst && rx_valid) begin
      rx_log[rx_cnt % 64] = rx_data;
      rx_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic user_write(input logic [W-1:0] d);
    @(negedge clk); tx_data = d; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
    check(tx_ack == 1'b1, "R5 ack after write", tx_ack, 1);
    @(negedge clk);
    check(tx_ack == 1'b0, "R5 single ack", tx_ack, 0);
  endtask

  // Wait one half period; optionally issue a write timed to the cycle in
  // which the last edge takes effect (toggle + sync stages + edge register).
  task automatic half(input bit col, input logic [W-1:0] cd);
    for (int j = 0; j < H; j++) begin
      @(negedge clk);
      if (col && j == 1) begin tx_data = cd; tx_wr = 1'b1; end
      if (col && j == 2) begin
        check(tx_ack == 1'b1, "R8 ack at boundary write", tx_ack, 1);
        tx_wr = 1'b0;
      end
    end
  endtask

  task automatic stream(input int nw, input int col_w, input int col_b, input logic [W-1:0] cd);
    for (int w = 0; w < 4; w++) mi_a[w] = '0;
    sck  = cpol;
    mosi = cpha ? 1'b0 : mo_a[0][W-1];
    @(negedge clk); ss_n = 1'b0;
    repeat (SETTLE) @(negedge clk);
    for (int w = 0; w < nw; w++) begin
      for (int b = W-1; b >= 0; b--) begin
        if (!cpha) begin
          sck = ~sck; mi_a[w][b] = miso;
          half(1'b0, '0);
          sck = ~sck;
          if (b > 0) mosi = mo_a[w][b-1];
          else if (w + 1 < nw) mosi = mo_a[w+1][W-1];
          half((col_w == w) && (col_b == b), cd);
        end else begin
          sck = ~sck; mosi = mo_a[w][b];
          half(1'b0, '0);
          sck = ~sck; mi_a[w][b] = miso;
          half(1'b0, '0);
        end
      end
    end
    ss_n = 1'b1;
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic run(input int nw, input int col_w, input int col_b, input logic [W-1:0] cd, input string tag);
    int base;
    base = rx_cnt;
    stream(nw, col_w, col_b, cd);
    for (int w = 0; w < nw; w++) begin
      check(mi_a[w] == exp_a[w], {tag, " MISO word"}, mi_a[w], exp_a[w]);
      check(rx_log[(base + w) % 64] == mo_a[w], {tag, " R4 rx word"}, rx_log[(base + w) % 64], mo_a[w]);
    end
    check(rx_cnt - base == nw, {tag, " R4 rx count"}, rx_cnt - base, nw);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog (all R): actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(miso == 1'b0, "R10 miso after reset", miso, 0);
    check(rx_valid == 1'b0, "R10 rx_valid after reset", rx_valid, 0);
    check(tx_ack == 1'b0, "R10 tx_ack after reset", tx_ack, 0);

    // R10: nothing written yet, zeros go out
    cpol = 0; cpha = 0;
    mo_a[0] = 8'h3C; exp_a[0] = 8'h00;
    run(1, -1, -1, '0, "R10");

    // R1 R2: table of all four modes
    for (int v = 0; v < 8; v++) begin
      cpol = VEC[v][17]; cpha = VEC[v][16];
      repeat (4) @(negedge clk);
      user_write(VEC[v][7:0]);
      mo_a[0] = VEC[v][15:8]; exp_a[0] = VEC[v][7:0];
      run(1, -1, -1, '0, "R1 R2 mode table");
    end

    // R3: CPHA 0 presents MSB before any edge
    cpol = 1; cpha = 0;
    user_write(8'hA5);
    sck = cpol;
    @(negedge clk); ss_n = 1'b0;
    repeat (SETTLE) @(negedge clk);
    check(miso == 1'b1, "R3 MSB before first edge", miso, 1);
    ss_n = 1'b1;
    repeat (SETTLE) @(negedge clk);
    check(miso == 1'b0, "R9 idle MISO after deselect", miso, 0);

    // R6: repeat without writes, in both phases
    cpol = 0; cpha = 0;
    mo_a[0] = 8'h11; mo_a[1] = 8'h22; mo_a[2] = 8'h33;
    exp_a[0] = 8'hA5; exp_a[1] = 8'hA5; exp_a[2] = 8'hA5;
    run(3, -1, -1, '0, "R6 repeat cpha0");
    user_write(8'h5A);
    cpha = 1;
    exp_a[0] = 8'h5A; exp_a[1] = 8'h5A; exp_a[2] = 8'h5A;
    run(3, -1, -1, '0, "R6 repeat cpha1");

    // R5: latest write wins
    cpol = 1; cpha = 1;
    user_write(8'hC3);
    user_write(8'h96);
    mo_a[0] = 8'h44; mo_a[1] = 8'h55;
    exp_a[0] = 8'h96; exp_a[1] = 8'h96;
    run(2, -1, -1, '0, "R5 latest write");

    // R7: write in mid-word goes to next word
    cpol = 0; cpha = 0;
    mo_a[0] = 8'h0A; mo_a[1] = 8'hB0;
    exp_a[0] = 8'h96; exp_a[1] = 8'h4B;
    run(2, 0, 4, 8'h4B, "R7 mid-word write");

    // R8: write in the boundary load cycle waits one word
    mo_a[0] = 8'h01; mo_a[1] = 8'h02; mo_a[2] = 8'h03;
    exp_a[0] = 8'h4B; exp_a[1] = 8'h4B; exp_a[2] = 8'h77;
    run(3, 0, 0, 8'h77, "R8 boundary write");

    // R9: abort a partial word
    begin
      int base;
      base = rx_cnt;
      sck = cpol; mosi = 1'b1;
      @(negedge clk); ss_n = 1'b0;
      repeat (SETTLE) @(negedge clk);
      for (int b = 0; b < 3; b++) begin
        sck = ~sck; half(1'b0, '0);
        sck = ~sck; half(1'b0, '0);
      end
      ss_n = 1'b1;
      repeat (SETTLE) @(negedge clk);
      check(rx_cnt == base, "R9 no rx_valid on abort", rx_cnt - base, 0);
      check(miso == 1'b0, "R9 idle MISO after abort", miso, 0);
    end
    mo_a[0] = 8'hE7; exp_a[0] = 8'h77;
    run(1, -1, -1, '0, "R9 clean word after abort");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule